// File: doc/BRIEF.md
# Banked Two-Stage Row Decoder

This block selects one row of a memory bank. It takes a binary row address and drives a one-hot wordline vector. The decode happens in two stages. First, the address is cut into 2-bit pairs, and each pair is decoded to four lines. Second, one line from every pair is ANDed to form each wordline.

A bank-select input gates every wordline, so a bank that is not addressed keeps all its rows off. An enable input clears both stages. The pair decodes are brought out on their own port, so the intermediate stage can be observed directly.

The address width is a parameter. It may be 4 bits (16 wordlines) or 8 bits (256 wordlines). In the 8-bit form, two 16-line sub-decodes are built, and their outputs are ANDed pairwise.

Top module: `rowdec_banked`

## Requirements
- R1: With `dec_en` and `bank_sel` both high, exactly one wordline is high, and its index equals the binary value of `row_addr`.
- R2: With `dec_en` high, pair group g drives `pre_oh[4g+3:4g]` one-hot. Bit 4g+v is high, where v is the value of `row_addr[2g+1:2g]`. Group 0 decodes the least significant pair.
- R3: The wordline index is composed from the pair values, with the upper pair most significant (index = sum of v_g·4^g). Whenever any wordline is high, every pair group has an active line.
- R4: With `bank_sel` low, every wordline is low, whatever the address. The pair groups still decode as in R2.
- R5: With `dec_en` low, every wordline and every `pre_oh` bit is low.
- R6: The same rules hold with `ABITS` set to 8, giving 256 wordlines from four pair groups. A width other than 4 or 8 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| row_addr | input | ABITS | Binary row address |
| bank_sel | input | 1 | Bank is addressed; gates all wordlines |
| dec_en | input | 1 | Decoder enable; low clears both stages |
| wl | output | 2**ABITS | One-hot wordline vector |
| pre_oh | output | 2*ABITS | Pair-decode lines, four per 2-bit group |

## Verification
The hardest case to reach from the ports is a wordline that is correctly off while the pair stage is still active. This happens when the bank is deselected but the decoder is enabled. A fault that leaks a single row, or that gates the wrong stage, shows only for particular addresses.

The stimulus therefore sweeps every address under all four combinations of enable and bank select, for both widths. Each full wordline vector and each pair-decode vector is compared against values computed arithmetically from the address.

// File: rtl/rowdec_banked.sv
module rowdec_banked #(
  parameter int ABITS = 4,
  localparam int NGRP = ABITS / 2,
  localparam int NWL  = 1 << ABITS
) (
  input  logic [ABITS-1:0]  row_addr,
  input  logic              bank_sel,
  input  logic              dec_en,
  output logic [NWL-1:0]    wl,
  output logic [4*NGRP-1:0] pre_oh
);

  genvar g, i;

  for (g = 0; g < NGRP; g++) begin : g_pair
    assign pre_oh[4*g +: 4] = dec_en ? (4'b0001 << row_addr[2*g +: 2]) : 4'b0000;
  end

  if (ABITS == 4) begin : g_w4
    for (i = 0; i < 16; i++) begin : g_wl
      assign wl[i] = bank_sel & pre_oh[4 + i/4] & pre_oh[i%4];
    end
  end else if (ABITS == 8) begin : g_w8
    logic [15:0] hi16, lo16;
    for (i = 0; i < 16; i++) begin : g_mid
      assign hi16[i] = pre_oh[12 + i/4] & pre_oh[8 + i%4];
      assign lo16[i] = pre_oh[4 + i/4]  & pre_oh[i%4];
    end
    for (i = 0; i < 256; i++) begin : g_wl
      assign wl[i] = bank_sel & hi16[i/16] & lo16[i%16];
    end
  end else begin : g_bad
    $error("rowdec_banked: ABITS must be 4 or 8");
  end

  always_comb begin
    if (!$isunknown({row_addr, bank_sel, dec_en})) begin
      if (dec_en && bank_sel)
        a_r1_onehot: assert ($onehot(wl));
      if (!bank_sel)
        a_r4_bank_off: assert (wl == '0);
      if (!dec_en)
        a_r5_idle: assert (wl == '0 && pre_oh == '0);
      for (int k = 0; k < NGRP; k++) begin
        if (dec_en)
          a_r2_group: assert ($onehot(pre_oh[4*k +: 4]));
        if (|wl)
          a_r3_stage_link: assert (|pre_oh[4*k +: 4]);
      end
    end
  end

endmodule

// File: tb/sim_rowdec_banked.sv
module sim_rowdec_banked;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]   a4;
  logic [7:0]   a8;
  logic         bs, en;
  logic [15:0]  wl4;
  logic [7:0]   p4;
  logic [255:0] wl8;
  logic [15:0]  p8;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rowdec_banked #(.ABITS(4)) u0 (.row_addr(a4), .bank_sel(bs), .dec_en(en), .wl(wl4), .pre_oh(p4));
  rowdec_banked #(.ABITS(8)) u1 (.row_addr(a8), .bank_sel(bs), .dec_en(en), .wl(wl8), .pre_oh(p8));

  function automatic logic [15:0] exp_pre(input logic [7:0] a, input int ng, input logic e);
    logic [15:0] r = '0;
    for (int g = 0; g < ng; g++)
      if (e) r[4*g + int'((a >> (2*g)) & 8'd3)] = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s addr4=%0d addr8=%0d bs=%0b en=%0b act=%h exp=%h", req, a4, a8, bs, en, act, exp);
    end
  endtask

  task automatic check_now();
    logic [255:0] e8;
    logic [15:0]  e4;
    logic [15:0]  ep4, ep8;
    e4  = (en && bs) ? (16'd1 << a4) : 16'd0;
    e8  = (en && bs) ? (256'd1 << a8) : 256'd0;
    ep4 = exp_pre({4'd0, a4}, 2, en);
    ep8 = exp_pre(a8, 4, en);
    if (!en)            chk(wl4 == 0 && p4 == 0, "R5", {wl4, p4}, 0);
    else if (!bs)       chk(wl4 == 0, "R4", wl4, 0);
    else                chk(wl4 == e4, "R1/R3", wl4, e4);
    if (en)             chk(p4 == ep4[7:0], "R2", p4, ep4[7:0]);
    chk(wl8 == e8, "R6 wordlines", wl8, e8);
    chk(p8 == ep8, "R6 predecode", p8, ep8);
  endtask

  initial begin
    a4 = 0; a8 = 0; bs = 0; en = 0;
    repeat (2) @(negedge clk);
    chk(wl4 == 0 && p4 == 0 && wl8 == 0 && p8 == 0, "R5 reset-state", {wl4, p4}, 0);
    for (int m = 0; m < 4; m++) begin
      en = m[1]; bs = m[0];
      for (int a = 0; a < 256; a++) begin
        a8 = 8'(a); a4 = 4'(a);
        @(negedge clk); #1;
        check_now();
      end
    end
    en = 1; bs = 1; a4 = 4'hF; a8 = 8'hFF;
    @(negedge clk); #1;
    chk(wl4[15] && $onehot(wl4), "R1 top row", wl4, 16'h8000);
    chk(wl8[255] && $onehot(wl8), "R6 top row", wl8, {1'b1, 255'd0});
    bs = 0;
    @(negedge clk); #1;
    chk(wl4 == 0 && p4 == 8'h88, "R4 deselect keeps predecode", {wl4, p4}, 24'h000088);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule